// File: doc/BRIEF.md
# Stack and Interrupt Sequencer

This block runs the stack and program-flow sequences of an 8-bit processor core. The stack sits in one fixed 256-byte page of a 16-bit address space and is indexed by an 8-bit stack pointer. The block owns the stack pointer and the status byte, and it drives a byte-wide memory port with separate read and write strobes. The memory returns read data one cycle after the read strobe. A sequence starts with a one-cycle start request carrying an operation code and its operands. The block then steps through the required memory accesses, one per cycle, and raises a done pulse in the last step. It ends with an updated program counter, stack pointer, status byte and accumulator.

The surrounding core supplies the current program counter, the jump target, the accumulator and the X register with every request. Those values are latched when the request is accepted, so the core may change them afterwards. The supported sequences are:

- accumulator and status push and pull
- subroutine call and return
- software break
- return from interrupt
- loading the program counter from the reset vector
- loading the stack pointer from X

Instruction fetch and arithmetic are left to other blocks.

Top module: `sseq_top`

## Requirements
- R1: After reset, the outputs hold these values: program counter 0x0000, stack pointer 0x00, status 0x00, accumulator 0x00. Busy and done are low, and neither memory strobe is active.
- R2: A start is accepted only while busy is low. Operation code and operands are taken at that clock edge. Done is high for one cycle, in the last step, and the results appear at the next edge. A start raised while busy is ignored. The step counts are: push 1, pull 2, call 2, return 3, break 6, return from interrupt 4, reset vector 3, stack pointer load 1, reserved 1. Read data is expected one cycle after the read strobe.
- R3: A push writes to 0x0100 + SP and then lowers SP by one, wrapping from 0x00 to 0xFF. Every write lands in that stack page.
- R4: A pull first raises SP by one, wrapping from 0xFF to 0x00, and then reads 0x0100 + SP. Pulling the accumulator (code 2) sets status bit 1 when the byte is zero and copies byte bit 7 into status bit 7. All other status bits are left unchanged.
- R5: A status push (code 1) stores the status with bits 4 and 5 forced to one, and leaves the status register unchanged. A status pull (code 3) loads the pulled byte with bits 4 and 5 forced to one.
- R6: A call (code 4) pushes the latched program counter minus one, high byte first and then low byte, and then loads the program counter from the target.
- R7: A return (code 5) pulls the low byte and then the high byte. The program counter becomes that 16-bit value plus one.
- R8: A break (code 6) pushes the latched program counter plus one as high byte and then low byte. It then pushes the status with bits 4 and 5 forced to one and sets status bit 2. Finally it reads 0xFFFE (low byte) and 0xFFFF (high byte) into the program counter.
- R9: A return from interrupt (code 7) pulls the status with bit 4 cleared. It then pulls the low and high program counter bytes and loads them without adding one.
- R10: The reset-vector operation (code 8) reads 0xFFFC (low byte) and 0xFFFD (high byte) into the program counter. It lowers SP by three and sets status bits 4 and 5.
- R11: The stack pointer load (code 9) copies X into SP. It changes no status bit and makes no memory access.
- R12: Codes 0 (accumulator push) and 10 to 15 are defined as follows. Code 0 writes the latched accumulator. Codes 10 to 15 finish in one step and make no memory access. For every code the accumulator output shows the latched accumulator and the program counter output shows the latched program counter, unless the sequence itself replaces them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request to begin a sequence |
| op_i | input | 4 | Operation code |
| pc_i | input | 16 | Current program counter, latched at start |
| target_i | input | 16 | Call target, latched at start |
| acc_i | input | 8 | Accumulator value, latched at start |
| x_i | input | 8 | X register value, latched at start |
| mem_rdata_i | input | 8 | Read data, valid one cycle after mem_re_o |
| mem_addr_o | output | 16 | Memory address |
| mem_wdata_o | output | 8 | Write data |
| mem_we_o | output | 1 | Write strobe |
| mem_re_o | output | 1 | Read strobe |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Last step of the sequence |
| pc_o | output | 16 | Program counter |
| sp_o | output | 8 | Stack pointer |
| status_o | output | 8 | Status byte |
| acc_o | output | 8 | Accumulator |

## Verification
The memory strobes change during step k, counted from the first cycle after the accepting edge. The done pulse comes in step n−1, where n is the step count the sequence must take. The registered results appear one edge after done. The bench samples every signal at the falling edge. At every falling edge it compares any active memory access against a queue of expected accesses, in order. It also counts the falling edges from acceptance to done and checks that count against the per-operation step count. Only at the falling edge after done does it compare program counter, stack pointer, status and accumulator against its reference model.

// File: rtl/sseq_pkg.sv
package sseq_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam int STEP_W = 3;

    localparam int ST_ZERO  = 1;
    localparam int ST_IRQ   = 2;
    localparam int ST_BRK   = 4;
    localparam int ST_ONE   = 5;
    localparam int ST_NEG   = 7;

    localparam logic [DATA_W-1:0] FIXED_MASK =
        DATA_W'((1 << ST_BRK) | (1 << ST_ONE));

    typedef enum logic [3:0] {
        OP_PUSH_A  = 4'd0,
        OP_PUSH_P  = 4'd1,
        OP_PULL_A  = 4'd2,
        OP_PULL_P  = 4'd3,
        OP_CALL    = 4'd4,
        OP_RET     = 4'd5,
        OP_BRK     = 4'd6,
        OP_RTI     = 4'd7,
        OP_RESET   = 4'd8,
        OP_LOAD_SP = 4'd9
    } sseq_op_e;

    typedef enum logic [1:0] {MEM_IDLE, MEM_RD, MEM_WR} mem_kind_e;

    typedef enum logic [2:0] {
        AD_STACK_CUR, AD_STACK_UP, AD_BRK_LO, AD_BRK_HI, AD_RST_LO, AD_RST_HI
    } addr_sel_e;

    typedef enum logic [1:0] {WD_ACC, WD_STATUS, WD_RET_HI, WD_RET_LO} wdata_sel_e;

    typedef enum logic [2:0] {SP_HOLD, SP_INC, SP_DEC, SP_LOAD, SP_DROP3} sp_act_e;

    typedef enum logic [2:0] {CAP_NONE, CAP_LO, CAP_ACC, CAP_PLAIN_P, CAP_RTI_P} cap_e;

    typedef enum logic [1:0] {PC_HOLD, PC_TARGET, PC_JOIN, PC_JOIN_INC} pc_act_e;

    typedef struct packed {
        mem_kind_e  mem;
        addr_sel_e  addr;
        wdata_sel_e wsel;
        sp_act_e    sp;
        cap_e       cap;
        pc_act_e    pc;
        logic       set_irq;
        logic       set_fixed;
        logic       last;
    } uop_t;

    typedef struct packed {
        logic              busy;
        logic [STEP_W-1:0] step;
        sseq_op_e          op;
        logic [ADDR_W-1:0] pc;
        logic [ADDR_W-1:0] tgt;
        logic [DATA_W-1:0] acc;
        logic [DATA_W-1:0] xv;
        logic [DATA_W-1:0] lo;
        logic [DATA_W-1:0] sp;
        logic [DATA_W-1:0] status;
    } seq_state_t;

endpackage

// File: rtl/sseq_uop_dec.sv
module sseq_uop_dec
    import sseq_pkg::*;
(
    input  sseq_op_e          op_i,
    input  logic [STEP_W-1:0] step_i,
    output uop_t              uop_o
);

    always_comb begin
        uop_o.mem       = MEM_IDLE;
        uop_o.addr      = AD_STACK_CUR;
        uop_o.wsel      = WD_ACC;
        uop_o.sp        = SP_HOLD;
        uop_o.cap       = CAP_NONE;
        uop_o.pc        = PC_HOLD;
        uop_o.set_irq   = 1'b0;
        uop_o.set_fixed = 1'b0;
        uop_o.last      = 1'b0;
        case (op_i)
            OP_PUSH_A: begin
                uop_o.mem  = MEM_WR;
                uop_o.wsel = WD_ACC;
                uop_o.sp   = SP_DEC;
                uop_o.last = 1'b1;
            end
            OP_PUSH_P: begin
                uop_o.mem  = MEM_WR;
                uop_o.wsel = WD_STATUS;
                uop_o.sp   = SP_DEC;
                uop_o.last = 1'b1;
            end
            OP_PULL_A, OP_PULL_P: begin
                if (step_i == 3'd0) begin
                    uop_o.mem  = MEM_RD;
                    uop_o.addr = AD_STACK_UP;
                    uop_o.sp   = SP_INC;
                end else begin
                    uop_o.cap  = (op_i == OP_PULL_A) ? CAP_ACC : CAP_PLAIN_P;
                    uop_o.last = 1'b1;
                end
            end
            OP_CALL: begin
                uop_o.mem = MEM_WR;
                uop_o.sp  = SP_DEC;
                if (step_i == 3'd0) begin
                    uop_o.wsel = WD_RET_HI;
                end else begin
                    uop_o.wsel = WD_RET_LO;
                    uop_o.pc   = PC_TARGET;
                    uop_o.last = 1'b1;
                end
            end
            OP_RET: begin
                case (step_i)
                    3'd0: begin
                        uop_o.mem  = MEM_RD;
                        uop_o.addr = AD_STACK_UP;
                        uop_o.sp   = SP_INC;
                    end
                    3'd1: begin
                        uop_o.mem  = MEM_RD;
                        uop_o.addr = AD_STACK_UP;
                        uop_o.sp   = SP_INC;
                        uop_o.cap  = CAP_LO;
                    end
                    default: begin
                        uop_o.pc   = PC_JOIN_INC;
                        uop_o.last = 1'b1;
                    end
                endcase
            end
            OP_BRK: begin
                case (step_i)
                    3'd0: begin
                        uop_o.mem  = MEM_WR;
                        uop_o.wsel = WD_RET_HI;
                        uop_o.sp   = SP_DEC;
                    end
                    3'd1: begin
                        uop_o.mem  = MEM_WR;
                        uop_o.wsel = WD_RET_LO;
                        uop_o.sp   = SP_DEC;
                    end
                    3'd2: begin
                        uop_o.mem     = MEM_WR;
                        uop_o.wsel    = WD_STATUS;
                        uop_o.sp      = SP_DEC;
                        uop_o.set_irq = 1'b1;
                    end
                    3'd3: begin
                        uop_o.mem  = MEM_RD;
                        uop_o.addr = AD_BRK_LO;
                    end
                    3'd4: begin
                        uop_o.mem  = MEM_RD;
                        uop_o.addr = AD_BRK_HI;
                        uop_o.cap  = CAP_LO;
                    end
                    default: begin
                        uop_o.pc   = PC_JOIN;
                        uop_o.last = 1'b1;
                    end
                endcase
            end
            OP_RTI: begin
                case (step_i)
                    3'd0: begin
                        uop_o.mem  = MEM_RD;
                        uop_o.addr = AD_STACK_UP;
                        uop_o.sp   = SP_INC;
                    end
                    3'd1: begin
                        uop_o.mem  = MEM_RD;
                        uop_o.addr = AD_STACK_UP;
                        uop_o.sp   = SP_INC;
                        uop_o.cap  = CAP_RTI_P;
                    end
                    3'd2: begin
                        uop_o.mem  = MEM_RD;
                        uop_o.addr = AD_STACK_UP;
                        uop_o.sp   = SP_INC;
                        uop_o.cap  = CAP_LO;
                    end
                    default: begin
                        uop_o.pc   = PC_JOIN;
                        uop_o.last = 1'b1;
                    end
                endcase
            end
            OP_RESET: begin
                case (step_i)
                    3'd0: begin
                        uop_o.mem  = MEM_RD;
                        uop_o.addr = AD_RST_LO;
                    end
                    3'd1: begin
                        uop_o.mem  = MEM_RD;
                        uop_o.addr = AD_RST_HI;
                        uop_o.cap  = CAP_LO;
                    end
                    default: begin
                        uop_o.pc        = PC_JOIN;
                        uop_o.sp        = SP_DROP3;
                        uop_o.set_fixed = 1'b1;
                        uop_o.last      = 1'b1;
                    end
                endcase
            end
            OP_LOAD_SP: begin
                uop_o.sp   = SP_LOAD;
                uop_o.last = 1'b1;
            end
            default: uop_o.last = 1'b1;
        endcase
    end

endmodule

// File: rtl/sseq_addr_unit.sv
module sseq_addr_unit
    import sseq_pkg::*;
#(
    parameter logic [7:0]        STACK_PAGE = 8'h01,
    parameter logic [ADDR_W-1:0] BRK_VEC    = 16'hFFFE,
    parameter logic [ADDR_W-1:0] RST_VEC    = 16'hFFFC
) (
    input  logic [DATA_W-1:0] sp_i,
    input  logic [DATA_W-1:0] x_i,
    input  addr_sel_e         addr_sel_i,
    input  sp_act_e           sp_act_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] sp_next_o
);

    localparam logic [DATA_W-1:0] RST_DROP = DATA_W'(3);

    logic [DATA_W-1:0] sp_up;
    assign sp_up = sp_i + DATA_W'(1);

    always_comb begin
        case (addr_sel_i)
            AD_STACK_UP: addr_o = {STACK_PAGE, sp_up};
            AD_BRK_LO:   addr_o = BRK_VEC;
            AD_BRK_HI:   addr_o = BRK_VEC + ADDR_W'(1);
            AD_RST_LO:   addr_o = RST_VEC;
            AD_RST_HI:   addr_o = RST_VEC + ADDR_W'(1);
            default:     addr_o = {STACK_PAGE, sp_i};
        endcase
    end

    always_comb begin
        case (sp_act_i)
            SP_INC:   sp_next_o = sp_up;
            SP_DEC:   sp_next_o = sp_i - DATA_W'(1);
            SP_LOAD:  sp_next_o = x_i;
            SP_DROP3: sp_next_o = sp_i - RST_DROP;
            default:  sp_next_o = sp_i;
        endcase
    end

endmodule

// File: rtl/sseq_status_unit.sv
module sseq_status_unit
    import sseq_pkg::*;
(
    input  logic [DATA_W-1:0] status_i,
    input  logic [DATA_W-1:0] rdata_i,
    input  cap_e              cap_i,
    input  logic              set_irq_i,
    input  logic              set_fixed_i,
    output logic [DATA_W-1:0] status_o,
    output logic [DATA_W-1:0] push_img_o
);

    assign push_img_o = status_i | FIXED_MASK;

    logic [DATA_W-1:0] loaded;

    always_comb begin
        loaded = status_i;
        case (cap_i)
            CAP_ACC: begin
                loaded[ST_ZERO] = (rdata_i == '0);
                loaded[ST_NEG]  = rdata_i[DATA_W-1];
            end
            CAP_PLAIN_P: loaded = rdata_i | FIXED_MASK;
            CAP_RTI_P: begin
                loaded         = rdata_i;
                loaded[ST_BRK] = 1'b0;
            end
            default: loaded = status_i;
        endcase
        status_o = loaded;
        if (set_irq_i)   status_o[ST_IRQ] = 1'b1;
        if (set_fixed_i) status_o = status_o | FIXED_MASK;
    end

endmodule

// File: rtl/sseq_top.sv
module sseq_top
    import sseq_pkg::*;
#(
    parameter logic [7:0]  STACK_PAGE   = 8'h01,
    parameter logic [15:0] BRK_VEC      = 16'hFFFE,
    parameter logic [15:0] RST_VEC      = 16'hFFFC,
    parameter logic [7:0]  SP_RESET     = 8'h00,
    parameter logic [7:0]  STATUS_RESET = 8'h00
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic [3:0]  op_i,
    input  logic [15:0] pc_i,
    input  logic [15:0] target_i,
    input  logic [7:0]  acc_i,
    input  logic [7:0]  x_i,
    input  logic [7:0]  mem_rdata_i,
    output logic [15:0] mem_addr_o,
    output logic [7:0]  mem_wdata_o,
    output logic        mem_we_o,
    output logic        mem_re_o,
    output logic        busy_o,
    output logic        done_o,
    output logic [15:0] pc_o,
    output logic [7:0]  sp_o,
    output logic [7:0]  status_o,
    output logic [7:0]  acc_o
);

    seq_state_t st_d, st_q;
    uop_t       uop;

    logic [DATA_W-1:0] sp_next;
    logic [DATA_W-1:0] status_next;
    logic [DATA_W-1:0] push_img;
    logic [ADDR_W-1:0] addr;
    logic [ADDR_W-1:0] ret_addr;
    logic [ADDR_W-1:0] joined;

    sseq_uop_dec dec_i (
        .op_i   (st_q.op),
        .step_i (st_q.step),
        .uop_o  (uop)
    );

    sseq_addr_unit #(
        .STACK_PAGE (STACK_PAGE),
        .BRK_VEC    (BRK_VEC),
        .RST_VEC    (RST_VEC)
    ) addr_i (
        .sp_i       (st_q.sp),
        .x_i        (st_q.xv),
        .addr_sel_i (uop.addr),
        .sp_act_i   (uop.sp),
        .addr_o     (addr),
        .sp_next_o  (sp_next)
    );

    sseq_status_unit stat_i (
        .status_i    (st_q.status),
        .rdata_i     (mem_rdata_i),
        .cap_i       (uop.cap),
        .set_irq_i   (uop.set_irq),
        .set_fixed_i (uop.set_fixed),
        .status_o    (status_next),
        .push_img_o  (push_img)
    );

    assign ret_addr = (st_q.op == OP_BRK) ? st_q.pc + ADDR_W'(1)
                                          : st_q.pc - ADDR_W'(1);
    assign joined   = {mem_rdata_i, st_q.lo};

    always_comb begin
        st_d = st_q;
        if (!st_q.busy) begin
            if (start_i) begin
                st_d.busy = 1'b1;
                st_d.step = '0;
                st_d.op   = sseq_op_e'(op_i);
                st_d.pc   = pc_i;
                st_d.tgt  = target_i;
                st_d.acc  = acc_i;
                st_d.xv   = x_i;
            end
        end else begin
            st_d.sp     = sp_next;
            st_d.status = status_next;
            if (uop.cap == CAP_LO)  st_d.lo  = mem_rdata_i;
            if (uop.cap == CAP_ACC) st_d.acc = mem_rdata_i;
            case (uop.pc)
                PC_TARGET:   st_d.pc = st_q.tgt;
                PC_JOIN:     st_d.pc = joined;
                PC_JOIN_INC: st_d.pc = joined + ADDR_W'(1);
                default:     st_d.pc = st_q.pc;
            endcase
            if (uop.last) begin
                st_d.busy = 1'b0;
                st_d.step = '0;
            end else begin
                st_d.step = st_q.step + STEP_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.busy   <= 1'b0;
            st_q.step   <= '0;
            st_q.op     <= OP_PUSH_A;
            st_q.pc     <= '0;
            st_q.tgt    <= '0;
            st_q.acc    <= '0;
            st_q.xv     <= '0;
            st_q.lo     <= '0;
            st_q.sp     <= SP_RESET;
            st_q.status <= STATUS_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (uop.wsel)
            WD_STATUS: mem_wdata_o = push_img;
            WD_RET_HI: mem_wdata_o = ret_addr[ADDR_W-1:DATA_W];
            WD_RET_LO: mem_wdata_o = ret_addr[DATA_W-1:0];
            default:   mem_wdata_o = st_q.acc;
        endcase
    end

    assign mem_addr_o = addr;
    assign mem_we_o   = st_q.busy && (uop.mem == MEM_WR);
    assign mem_re_o   = st_q.busy && (uop.mem == MEM_RD);
    assign busy_o     = st_q.busy;
    assign done_o     = st_q.busy && uop.last;
    assign pc_o       = st_q.pc;
    assign sp_o       = st_q.sp;
    assign status_o   = st_q.status;
    assign acc_o      = st_q.acc;

endmodule

// File: rtl/sseq_chk.sv
module sseq_chk #(
    parameter logic [7:0] STACK_PAGE = 8'h01
) (
    input logic        clk,
    input logic        rst_n,
    input logic        start_i,
    input logic        busy_o,
    input logic        done_o,
    input logic        mem_we_o,
    input logic        mem_re_o,
    input logic [15:0] mem_addr_o,
    input logic [7:0]  sp_o
);

    // R2
    accept_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);

    // R2
    done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o);

    // R2
    done_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> busy_o);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!mem_we_o && !mem_re_o));

    // R3
    stack_page_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> (mem_addr_o[15:8] == STACK_PAGE));

    // R3
    push_lowers_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |=> (sp_o == $past(sp_o) - 8'd1));

    // R2
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we_o && mem_re_o));

endmodule

bind sseq_top sseq_chk #(.STACK_PAGE(STACK_PAGE)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .mem_we_o   (mem_we_o),
    .mem_re_o   (mem_re_o),
    .mem_addr_o (mem_addr_o),
    .sp_o       (sp_o)
);

// File: tb/sseq_top_tb.sv
`timescale 1ns/1ps
module sseq_top_tb_top;

    localparam logic [3:0] C_PUSH_A = 4'd0, C_PUSH_P = 4'd1, C_PULL_A = 4'd2,
                           C_PULL_P = 4'd3, C_CALL = 4'd4, C_RET = 4'd5,
                           C_BRK = 4'd6, C_RTI = 4'd7, C_RESET = 4'd8,
                           C_LOAD_SP = 4'd9, C_RSVD = 4'd12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [3:0]  op_i = '0;
    logic [15:0] pc_i = '0, target_i = '0;
    logic [7:0]  acc_i = '0, x_i = '0;
    logic [7:0]  mem_rdata_i = '0;
    logic [15:0] mem_addr_o;
    logic [7:0]  mem_wdata_o;
    logic        mem_we_o, mem_re_o, busy_o, done_o;
    logic [15:0] pc_o;
    logic [7:0]  sp_o, status_o, acc_o;

    always #2.5 clk = ~clk;

    sseq_top dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i), .pc_i(pc_i),
        .target_i(target_i), .acc_i(acc_i), .x_i(x_i), .mem_rdata_i(mem_rdata_i),
        .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_we_o(mem_we_o),
        .mem_re_o(mem_re_o), .busy_o(busy_o), .done_o(done_o), .pc_o(pc_o),
        .sp_o(sp_o), .status_o(status_o), .acc_o(acc_o)
    );

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    logic [7:0] mem [int];

    typedef struct packed {
        logic        we;
        logic [15:0] addr;
        logic [7:0]  data;
    } access_t;
    access_t expq[$];

    logic [15:0] m_pc = '0;
    logic [7:0]  m_sp = '0, m_p = '0, m_a = '0;

    function automatic logic [7:0] rd(int a);
        return mem.exists(a) ? mem[a] : 8'h00;
    endfunction

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // memory with one-cycle read latency
    always @(posedge clk) begin
        if (mem_re_o) mem_rdata_i <= rd(int'(mem_addr_o));
        if (mem_we_o) mem[int'(mem_addr_o)] = mem_wdata_o;
    end

    // access monitor: compares every strobe against the expected queue (R3 R4)
    always @(negedge clk) begin
        if (rst_n && (mem_we_o || mem_re_o)) begin
            if (expq.size() == 0) begin
                checks++; failures++;
                $display("FAIL R3 unexpected access actual=%h expected=none", mem_addr_o);
            end else begin
                access_t e;
                e = expq.pop_front();
                chk("R3_R4 strobe kind", {15'd0, mem_we_o}, {15'd0, e.we});
                chk("R3_R4 address", mem_addr_o, e.addr);
                if (e.we) chk("R3 write data", {8'd0, mem_wdata_o}, {8'd0, e.data});
            end
        end
    end

    task automatic m_push(logic [7:0] v);
        expq.push_back({1'b1, 8'h01, m_sp, v});
        m_sp = m_sp - 8'd1;
    endtask

    task automatic m_pull(output logic [7:0] v);
        m_sp = m_sp + 8'd1;
        expq.push_back({1'b0, 8'h01, m_sp, 8'h00});
        v = rd(int'({8'h01, m_sp}));
    endtask

    task automatic m_read(logic [15:0] a, output logic [7:0] v);
        expq.push_back({1'b0, a, 8'h00});
        v = rd(int'(a));
    endtask

    task automatic model(logic [3:0] op, logic [15:0] pc, logic [15:0] tgt,
                         logic [7:0] a, logic [7:0] x, output int lat);
        logic [7:0] lo, hi, v;
        logic [15:0] r;
        m_pc = pc;
        m_a  = a;
        lat  = 1;
        case (op)
            C_PUSH_A: m_push(a);
            C_PUSH_P: m_push(m_p | 8'h30);
            C_PULL_A: begin
                m_pull(v); m_a = v;
                m_p[1] = (v == 8'h00); m_p[7] = v[7]; lat = 2;
            end
            C_PULL_P: begin m_pull(v); m_p = v | 8'h30; lat = 2; end
            C_CALL: begin
                r = pc - 16'd1; m_push(r[15:8]); m_push(r[7:0]);
                m_pc = tgt; lat = 2;
            end
            C_RET: begin m_pull(lo); m_pull(hi); m_pc = {hi, lo} + 16'd1; lat = 3; end
            C_BRK: begin
                r = pc + 16'd1; m_push(r[15:8]); m_push(r[7:0]);
                m_push(m_p | 8'h30); m_p[2] = 1'b1;
                m_read(16'hFFFE, lo); m_read(16'hFFFF, hi);
                m_pc = {hi, lo}; lat = 6;
            end
            C_RTI: begin
                m_pull(v); m_p = v & 8'hEF;
                m_pull(lo); m_pull(hi); m_pc = {hi, lo}; lat = 4;
            end
            C_RESET: begin
                m_read(16'hFFFC, lo); m_read(16'hFFFD, hi);
                m_pc = {hi, lo}; m_sp = m_sp - 8'd3; m_p = m_p | 8'h30; lat = 3;
            end
            C_LOAD_SP: m_sp = x;
            default: ;
        endcase
    endtask

    task automatic run_op(string tag, logic [3:0] op, logic [15:0] pc,
                          logic [15:0] tgt, logic [7:0] a, logic [7:0] x, bit hijack);
        int lat;
        int n;
        @(negedge clk);
        start_i = 1'b1; op_i = op; pc_i = pc; target_i = tgt; acc_i = a; x_i = x;
        model(op, pc, tgt, a, x, lat);
        n = 0;
        do begin
            @(negedge clk);
            n++;
            if (hijack) begin
                op_i = C_PUSH_A; pc_i = 16'hDEAD; acc_i = 8'hEE; x_i = 8'h11;
            end else begin
                start_i = 1'b0;
            end
        end while (!done_o && n < 20);
        start_i = 1'b0;
        chk({"R2 step count ", tag}, 16'(n), 16'(lat));
        @(negedge clk);
        chk({tag, " pc"}, pc_o, m_pc);
        chk({tag, " sp"}, {8'd0, sp_o}, {8'd0, m_sp});
        chk({tag, " status"}, {8'd0, status_o}, {8'd0, m_p});
        chk({tag, " acc"}, {8'd0, acc_o}, {8'd0, m_a});
        chk({tag, " R2 idle after done"}, {15'd0, busy_o}, 16'd0);
        chk({tag, " access queue drained"}, 16'(expq.size()), 16'd0);
    endtask

    initial begin
        mem[32'hFFFC] = 8'h00; mem[32'hFFFD] = 8'h80;
        mem[32'hFFFE] = 8'h34; mem[32'hFFFF] = 8'h12;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 pc", pc_o, 16'h0000);
        chk("R1 sp", {8'd0, sp_o}, 16'h0000);
        chk("R1 status", {8'd0, status_o}, 16'h0000);
        chk("R1 acc", {8'd0, acc_o}, 16'h0000);
        chk("R1 busy/done/strobes", {12'd0, busy_o, done_o, mem_we_o, mem_re_o}, 16'd0);

        run_op("R10 reset vector", C_RESET, 16'h0000, 16'h0, 8'h00, 8'h00, 0);
        run_op("R11 load sp zero", C_LOAD_SP, 16'h8000, 16'h0, 8'h00, 8'h00, 0);
        run_op("R3 push wrap", C_PUSH_A, 16'h8000, 16'h0, 8'h5A, 8'h00, 0);
        run_op("R4 pull wrap", C_PULL_A, 16'h8000, 16'h0, 8'h00, 8'h00, 0);
        run_op("R11 load sp F0", C_LOAD_SP, 16'h8000, 16'h0, 8'h00, 8'hF0, 0);
        run_op("R12 push zero", C_PUSH_A, 16'h8000, 16'h0, 8'h00, 8'h00, 0);
        run_op("R4 pull zero", C_PULL_A, 16'h8000, 16'h0, 8'h77, 8'h00, 0);
        run_op("R12 push neg", C_PUSH_A, 16'h8000, 16'h0, 8'h80, 8'h00, 0);
        run_op("R4 pull neg", C_PULL_A, 16'h8000, 16'h0, 8'h00, 8'h00, 0);
        run_op("R6 call", C_CALL, 16'h8003, 16'h9000, 8'h00, 8'h00, 0);
        run_op("R7 return", C_RET, 16'h9000, 16'h0, 8'h00, 8'h00, 0);
        run_op("R8 break", C_BRK, 16'h9001, 16'h0, 8'h00, 8'h00, 0);
        run_op("R9 return from interrupt", C_RTI, 16'h1234, 16'h0, 8'h00, 8'h00, 0);
        run_op("R5 push status", C_PUSH_P, 16'h9002, 16'h0, 8'h00, 8'h00, 0);
        mem[32'h01F0] = 8'h83;
        run_op("R5 pull status", C_PULL_P, 16'h9002, 16'h0, 8'h00, 8'h00, 0);
        run_op("R12 reserved code", C_RSVD, 16'h9002, 16'h0, 8'h00, 8'h00, 0);
        run_op("R2 start ignored while busy", C_BRK, 16'h4000, 16'h0, 8'h00, 8'h00, 1);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; failures++;
            $display("FAIL R2 watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule